// File: doc/BRIEF.md
# Segmented Waveform Sequencer

This block walks a small table of segment descriptors and produces read addresses for an external sample memory. Each descriptor gives a waveform's start word address, its length in samples, a repeat count and an optional marker position. Addresses are issued one four-sample word per clock. Each waveform repeats for its count, and a one-clock marker pulse appears on the word that holds the marker position.

There are two modes. Single mode replays only descriptor 0. Sequence mode plays descriptors 0 to N-1 in index order. A burst option ignores the repeat counts: the current segment repeats until a stop request arrives.

Playback starts on a trigger pulse. Before starting, the block checks every descriptor it is about to use. If any descriptor is malformed it raises a configuration error and stays idle. When playback ends it gives a one-cycle done pulse and returns to idle. The descriptor table can be written only while the block is idle.

Top module: `wave_sequencer`

## Requirements
- R1: After reset the block is idle and `busy`, `rd_valid`, `marker`, `done` and `cfg_err` are all 0. Every descriptor reads as zero, so it is invalid.
- R2: A trigger while idle with a valid configuration raises `busy` and `rd_valid` at the next clock edge, with `rd_addr` equal to descriptor 0's start address. A trigger while busy is ignored.
- R3: While busy, `rd_addr` is the segment start plus the word offset. The offset counts up by one per clock from 0 to len/4-1, where len is in samples. When idle, `rd_addr` is 0.
- R4: Outside burst mode, a segment plays its waveform exactly `loops` times back to back, then moves on.
- R5: In sequence mode (`mode_seq`=1) descriptors 0 to `seg_count`-1 play in index order. In single mode only descriptor 0 plays, whatever `seg_count` holds.
- R6: For an enabled marker, `marker` is high for one clock on word offset mk_pos/4, on every repeat. A disabled marker never pulses.
- R7: In the cycle after the last word of the final segment, `busy` is 0 and `done` is 1 for exactly one clock.
- R8: At a trigger while idle, `cfg_err` takes the outcome of a configuration check, and on error the block does not start. The check fails if any used descriptor has a length that is not a multiple of 4, a length below 16, zero loops outside burst, or an enabled marker that is not a multiple of 4 or not below the length. It also fails if the used count is 0 or above the table depth.
- R9: In burst mode (`burst`=1 at the trigger) loop counts are ignored, so zero is allowed, and each segment repeats until a `stop` pulse. After the stop, the segment finishes its current pass and playback advances to the next segment or ends.
- R10: `stop` has no effect outside burst mode.
- R11: Descriptor writes while busy are discarded. Writes while idle update the descriptor at `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Start pulse |
| mode_seq | input | 1 | 1 = sequence mode, 0 = single mode |
| burst | input | 1 | Repeat segments until stopped |
| stop | input | 1 | Ends the current burst segment at the end of its pass |
| seg_count | input | CNT_W | Number of descriptors used in sequence mode |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | IDX_W | Descriptor index to write |
| wr_start | input | SA_W (16) | Start word address |
| wr_len | input | SL_W (18) | Length in samples |
| wr_loops | input | LOOP_W (24) | Repeat count |
| wr_mk_en | input | 1 | Marker enable |
| wr_mk_pos | input | SL_W (18) | Marker sample position |
| rd_addr | output | SA_W (16) | Sample memory word address |
| rd_valid | output | 1 | Address valid |
| marker | output | 1 | Marker pulse |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle end-of-playback pulse |
| cfg_err | output | 1 | Result of the last trigger's configuration check |

## Verification
On every cycle the embedded assertions check the following: addresses step by one inside a pass, the word offset stays inside the waveform, markers and the done pulse appear only in the correct states, and a configuration error never coincides with a start. They also check that the table stays frozen while busy. Only the bench's scenarios can show the rest. These are the exact repeat counts, segment order in each mode, marker placement per pass, rejection of each malformed descriptor, and the stop handshake in burst mode. They are compared against a behavioural model every clock.

// File: rtl/wseq_pkg.sv
// Shared widths and the segment descriptor type for the waveform sequencer.
// Assumes sample lengths and marker positions are given in samples, and
// addresses in four-sample words.
package wseq_pkg;
    localparam int SA_W    = 16;  // word address width
    localparam int SL_W    = 18;  // sample length / position width
    localparam int LOOP_W  = 24;  // repeat count width
    localparam int QUANT   = 4;   // samples per memory word
    localparam int MIN_LEN = 16;  // shortest legal waveform in samples

    typedef struct packed {
        logic [SA_W-1:0]   start;
        logic [SL_W-1:0]   len;
        logic [LOOP_W-1:0] loops;
        logic              mk_en;
        logic [SL_W-1:0]   mk_pos;
    } seg_t;
endpackage

// File: rtl/seg_table.sv
// Descriptor storage in flops. Written only while the engine is idle so a
// running playback always sees a stable table. Assumes SEG_N >= 2.
module seg_table
    import wseq_pkg::*;
#(
    parameter int SEG_N = 8,
    localparam int IDX_W = $clog2(SEG_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  seg_t                wr_data,
    output seg_t [SEG_N-1:0]    tbl
);
    seg_t [SEG_N-1:0] tbl_q;

    // Clear on reset, accept idle-time writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (wr_en && !busy) begin
            tbl_q[wr_idx] <= wr_data;
        end
    end

    assign tbl = tbl_q;

    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tbl_q)); // R11
endmodule

// File: rtl/cfg_check.sv
// Combinational validity check over the descriptors that a playback would
// use. One checker slice per table entry; unused entries always pass.
module cfg_check
    import wseq_pkg::*;
#(
    parameter int SEG_N = 8,
    localparam int CNT_W = $clog2(SEG_N + 1)
) (
    input  seg_t [SEG_N-1:0] tbl,
    input  logic [CNT_W-1:0] n_used,
    input  logic             burst,
    output logic             bad
);
    logic [SEG_N-1:0] ok;

    for (genvar i = 0; i < SEG_N; i++) begin : g_slice
        logic len_ok, loop_ok, mk_ok;
        // Length aligned to the word quantum and not below the minimum.
        assign len_ok  = (tbl[i].len[1:0] == 2'b00) && (tbl[i].len >= SL_W'(MIN_LEN));
        // A zero repeat count is legal only when counts are ignored.
        assign loop_ok = burst || (tbl[i].loops != '0);
        // Marker aligned and inside the waveform when enabled.
        assign mk_ok   = !tbl[i].mk_en ||
                         ((tbl[i].mk_pos[1:0] == 2'b00) && (tbl[i].mk_pos < tbl[i].len));
        assign ok[i]   = (CNT_W'(i) >= n_used) || (len_ok && loop_ok && mk_ok);
    end

    // Any failing slice or an out-of-range count rejects the start.
    always_comb begin
        bad = !(&ok) || (n_used == '0) || (n_used > CNT_W'(SEG_N));
    end
endmodule

// File: rtl/play_engine.sv
// Playback state machine: segment index, word offset inside the waveform
// and remaining repeats. Outputs are decoded from state with no extra
// pipeline, so an address appears in the cycle its state is held.
// Assumes the table does not change while busy.
module play_engine
    import wseq_pkg::*;
#(
    parameter int SEG_N = 8,
    localparam int IDX_W = $clog2(SEG_N),
    localparam int CNT_W = $clog2(SEG_N + 1),
    localparam int OFF_W = SL_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              burst,
    input  logic              stop,
    input  logic [CNT_W-1:0]  n_used,
    input  logic              cfg_bad,
    input  seg_t [SEG_N-1:0]  tbl,
    output logic [SA_W-1:0]   rd_addr,
    output logic              rd_valid,
    output logic              marker,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    logic               busy_q, done_q, err_q, burst_q, stop_q;
    logic [IDX_W-1:0]   seg_q, last_q, seg_nx;
    logic [OFF_W-1:0]   off_q;
    logic [LOOP_W-1:0]  loops_q, nxt_loops;
    seg_t               cur;
    logic               last_word, fin;

    // Current and following descriptor fields.
    always_comb begin
        cur       = tbl[seg_q];
        seg_nx    = seg_q + 1'b1;
        nxt_loops = tbl[seg_nx].loops;
    end

    // End-of-pass and end-of-segment decisions.
    always_comb begin
        last_word = (SL_W'(off_q) == (cur.len >> 2) - SL_W'(1));
        fin       = burst_q ? (stop_q || stop) : (loops_q == LOOP_W'(1));
    end

    // Sequencing of segments, passes and words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            burst_q <= 1'b0;
            stop_q  <= 1'b0;
            seg_q   <= '0;
            last_q  <= '0;
            off_q   <= '0;
            loops_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                if (last_word) begin
                    off_q <= '0;
                    if (fin) begin
                        stop_q <= 1'b0;
                        if (seg_q == last_q) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            seg_q   <= seg_nx;
                            loops_q <= nxt_loops;
                        end
                    end else if (!burst_q) begin
                        loops_q <= loops_q - 1'b1;
                    end
                end else begin
                    off_q <= off_q + 1'b1;
                    if (stop && burst_q) stop_q <= 1'b1;
                end
            end else if (trig) begin
                err_q <= cfg_bad;
                if (!cfg_bad) begin
                    busy_q  <= 1'b1;
                    seg_q   <= '0;
                    off_q   <= '0;
                    loops_q <= tbl[0].loops;
                    last_q  <= IDX_W'(n_used - 1'b1);
                    burst_q <= burst;
                    stop_q  <= 1'b0;
                end
            end
        end
    end

    // Output decode from held state.
    always_comb begin
        rd_valid = busy_q;
        rd_addr  = busy_q ? (cur.start + SA_W'(off_q)) : '0;
        marker   = busy_q && cur.mk_en && ({off_q, 2'b00} == cur.mk_pos);
        busy     = busy_q;
        done     = done_q;
        cfg_err  = err_q;
    end

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (seg_q == '0 && off_q == '0)); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && off_q != '0) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R3
    AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ({off_q, 2'b00} < cur.len)); // R3
    AST_MARK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        marker |-> busy_q); // R6
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_q, done_q})); // R7
    AST_ERR_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !busy_q); // R8
endmodule

// File: rtl/wave_sequencer.sv
// Top of the segmented waveform sequencer: descriptor table, start-time
// configuration check and playback engine. Assumes SEG_N >= 2 and that
// mode inputs are stable around the trigger.
module wave_sequencer
    import wseq_pkg::*;
#(
    parameter int SEG_N = 8,
    localparam int IDX_W = $clog2(SEG_N),
    localparam int CNT_W = $clog2(SEG_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              mode_seq,
    input  logic              burst,
    input  logic              stop,
    input  logic [CNT_W-1:0]  seg_count,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SA_W-1:0]   wr_start,
    input  logic [SL_W-1:0]   wr_len,
    input  logic [LOOP_W-1:0] wr_loops,
    input  logic              wr_mk_en,
    input  logic [SL_W-1:0]   wr_mk_pos,
    output logic [SA_W-1:0]   rd_addr,
    output logic              rd_valid,
    output logic              marker,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    seg_t [SEG_N-1:0] tbl;
    seg_t             wr_data;
    logic [CNT_W-1:0] n_used;
    logic             cfg_bad;

    // Pack the write fields and pick the descriptor count for the mode.
    always_comb begin
        wr_data = '{start: wr_start, len: wr_len, loops: wr_loops,
                    mk_en: wr_mk_en, mk_pos: wr_mk_pos};
        n_used  = mode_seq ? seg_count : CNT_W'(1);
    end

    seg_table #(.SEG_N(SEG_N)) i_table (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .tbl(tbl)
    );

    cfg_check #(.SEG_N(SEG_N)) i_check (
        .tbl(tbl), .n_used(n_used), .burst(burst), .bad(cfg_bad)
    );

    play_engine #(.SEG_N(SEG_N)) i_engine (
        .clk(clk), .rst_n(rst_n), .trig(trig), .burst(burst), .stop(stop),
        .n_used(n_used), .cfg_bad(cfg_bad), .tbl(tbl),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .marker(marker),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );
endmodule

// File: tb/test_wave_sequencer.sv
module test_wave_sequencer;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        trig = 0, mode_seq = 0, burst = 0, stop = 0;
    logic [3:0]  seg_count = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_idx = 0;
    logic [15:0] wr_start = 0;
    logic [17:0] wr_len = 0, wr_mk_pos = 0;
    logic [23:0] wr_loops = 0;
    logic        wr_mk_en = 0;
    logic [15:0] rd_addr;
    logic        rd_valid, marker, busy, done, cfg_err;

    always #2.5 clk = ~clk;

    wave_sequencer i_wave_sequencer (.*);

    int total = 0, bad = 0, cyc = 0;
    bit mon_on = 0;
    int cnt_busy = 0, cnt_mk = 0, cnt_done = 0;

    // Shadow of what the table should hold.
    int s_start[8], s_len[8], s_loops[8], s_mk[8];
    bit s_mken[8];
    // Reference model state.
    bit m_busy = 0, m_done = 0, m_err = 0, m_bst = 0, m_stp = 0;
    int m_seg = 0, m_off = 0, m_lp = 0, m_last = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cfg_bad_m(int n, bit bst);
        if (n < 1 || n > 8) return 1;
        for (int i = 0; i < n; i++) begin
            if (s_len[i] % 4 != 0 || s_len[i] < 16) return 1;
            if (!bst && s_loops[i] == 0) return 1;
            if (s_mken[i] && (s_mk[i] % 4 != 0 || s_mk[i] >= s_len[i])) return 1;
        end
        return 0;
    endfunction

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_stp = 0;
            for (int i = 0; i < 8; i++) begin
                s_start[i] = 0; s_len[i] = 0; s_loops[i] = 0; s_mk[i] = 0; s_mken[i] = 0;
            end
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_off == s_len[m_seg] / 4 - 1) begin
                    bit fin;
                    fin = m_bst ? (m_stp || stop) : (m_lp == 1);
                    m_off = 0;
                    if (fin) begin
                        m_stp = 0;
                        if (m_seg == m_last) begin m_busy = 0; m_done = 1; end
                        else begin m_seg++; m_lp = s_loops[m_seg]; end
                    end else if (!m_bst) m_lp--;
                end else begin
                    m_off++;
                    if (stop && m_bst) m_stp = 1;
                end
            end else if (trig) begin
                int n;
                n = mode_seq ? int'(seg_count) : 1;
                m_err = cfg_bad_m(n, burst);
                if (!m_err) begin
                    m_busy = 1; m_seg = 0; m_off = 0; m_lp = s_loops[0];
                    m_last = n - 1; m_bst = burst; m_stp = 0;
                end
            end
        end
    end

    // Compare against the model 1 ns after every rising edge.
    always @(posedge clk) begin
        cyc++;
        #1;
        if (mon_on) begin
            int e_addr;
            bit e_mk;
            e_addr = m_busy ? ((s_start[m_seg] + m_off) & 16'hFFFF) : 0;
            e_mk = m_busy && s_mken[m_seg] && (m_off * 4 == s_mk[m_seg]);
            check(rd_valid == m_busy && busy == m_busy, "R2 busy/rd_valid", int'(busy), int'(m_busy));
            check(int'(rd_addr) == e_addr, "R3 rd_addr", int'(rd_addr), e_addr);
            check(marker == e_mk, "R6 marker", int'(marker), int'(e_mk));
            check(done == m_done, "R7 done", int'(done), int'(m_done));
            check(cfg_err == m_err, "R8 cfg_err", int'(cfg_err), int'(m_err));
            if (busy) cnt_busy++;
            if (marker) cnt_mk++;
            if (done) cnt_done++;
        end
        if (cyc > 50000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr_seg(input int idx, input int st, input int ln, input int lp,
                          input bit mke, input int mk, input bit upd);
        @(negedge clk);
        wr_en = 1; wr_idx = 3'(idx); wr_start = 16'(st); wr_len = 18'(ln);
        wr_loops = 24'(lp); wr_mk_en = mke; wr_mk_pos = 18'(mk);
        if (upd) begin
            s_start[idx] = st; s_len[idx] = ln; s_loops[idx] = lp;
            s_mken[idx] = mke; s_mk[idx] = mk;
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1;
        @(negedge clk); trig = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    initial begin
        int b0, k0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);
        // R1: reset state.
        check(!busy && !rd_valid && !marker && !done && !cfg_err, "R1 idle after reset",
              int'({busy, rd_valid, marker, done, cfg_err}), 0);

        // Table: seg0 4 words x2 marker word 2; seg1 5 words x1; seg2 4 words x3 marker word 0.
        wr_seg(0, 100, 16, 2, 1, 8, 1);
        wr_seg(1, 200, 20, 1, 0, 0, 1);
        wr_seg(2, 300, 16, 3, 1, 0, 1);

        // R4/R5: single mode plays only seg0, twice.
        mode_seq = 0; seg_count = 3;
        b0 = cnt_busy; k0 = cnt_mk; d0 = cnt_done;
        pulse_trig();
        wait_done();
        check(cnt_busy - b0 == 8, "R4 single-mode busy cycles", cnt_busy - b0, 8);
        check(cnt_busy - b0 == 8, "R5 single mode ignores seg_count", cnt_busy - b0, 8);
        check(cnt_mk - k0 == 2, "R6 marker once per pass", cnt_mk - k0, 2);
        check(cnt_done - d0 == 1, "R7 one done pulse", cnt_done - d0, 1);

        // R5/R10/R11/R2: sequence with stop, retrigger and write while busy.
        mode_seq = 1; seg_count = 3;
        b0 = cnt_busy; k0 = cnt_mk;
        pulse_trig();
        wr_seg(1, 900, 32, 4, 1, 4, 0);
        pulse_stop();
        pulse_trig();
        wait_done();
        check(cnt_busy - b0 == 25, "R5 sequence length", cnt_busy - b0, 25);
        check(cnt_busy - b0 == 25, "R10 stop ignored outside burst", cnt_busy - b0, 25);
        check(cnt_busy - b0 == 25, "R11 busy-time write discarded", cnt_busy - b0, 25);
        check(cnt_busy - b0 == 25, "R2 retrigger while busy ignored", cnt_busy - b0, 25);
        check(cnt_mk - k0 == 5, "R6 markers in sequence", cnt_mk - k0, 5);

        // R8: each malformed configuration is rejected.
        for (int c = 0; c < 7; c++) begin
            wr_seg(0, 100, 16, 2, 1, 8, 1);
            mode_seq = 1; seg_count = 3;
            case (c)
                0: wr_seg(0, 100, 18, 2, 0, 0, 1);
                1: wr_seg(0, 100, 12, 2, 0, 0, 1);
                2: wr_seg(0, 100, 16, 0, 0, 0, 1);
                3: wr_seg(0, 100, 16, 2, 1, 6, 1);
                4: wr_seg(0, 100, 16, 2, 1, 16, 1);
                5: seg_count = 0;
                default: seg_count = 9;
            endcase
            pulse_trig();
            repeat (3) @(negedge clk);
            check(cfg_err && !busy, $sformatf("R8 reject case %0d", c),
                  int'({cfg_err, busy}), 2);
        end
        wr_seg(0, 100, 16, 2, 1, 8, 1);
        seg_count = 1;
        pulse_trig();
        @(negedge clk);
        check(!cfg_err && busy, "R8 valid trigger clears error", int'({cfg_err, busy}), 1);
        wait_done();

        // R9: burst mode, zero loop counts, stop advances segment by segment.
        wr_seg(0, 500, 16, 0, 1, 4, 1);
        wr_seg(1, 600, 24, 0, 0, 0, 1);
        mode_seq = 1; seg_count = 2; burst = 1;
        pulse_trig();
        repeat (30) @(negedge clk);
        check(busy, "R9 burst repeats without end", int'(busy), 1);
        pulse_stop();
        repeat (20) @(negedge clk);
        check(busy && rd_addr >= 600 && rd_addr < 606, "R9 stop moves to next segment",
              int'(rd_addr), 600);
        d0 = cnt_done;
        pulse_stop();
        repeat (10) @(negedge clk);
        check(!busy && cnt_done - d0 == 1, "R9 final stop ends playback", cnt_done - d0, 1);
        burst = 0;

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule